// File: doc/BRIEF.md
# Home-Node Ownership Request Handler

This block sits at the home node of a directory-based coherence scheme. For every line it keeps a directory entry, made of a 2-bit state and a one-bit-per-node holder vector. It also keeps a small queue per line, so that requests to the same line are served strictly one after another. A request for ownership is served only when all of these hold: the directory shows the line as Shared, the local probe reports that memory holds valid data, and no eviction of that line is still travelling toward memory.

When the request is served, the block sends one invalidate to each holder other than the requester, lowest node number first. It then sends an exclusive grant to the requester. The grant carries the number of invalidates issued, so the requester knows how many acknowledgements to wait for. The grant handshake is the commit point. On that handshake the directory moves to Exclusive with the requester as sole holder. If the requester is the home node itself, the line goes to Stale instead. The head of the line's queue is removed at the same moment.

Other protocol phases update the directory through a write port and read it through a combinational read port. Eviction start and eviction arrival events maintain one in-flight bit per line.

Top module: `rfo_home_ctrl`

## Requirements
- R1: After reset every directory entry reads state Invalid (0) with an all-zero holder vector, `msg_valid` and `victim_clash` are 0, and `req_ready` is 1.
- R2: Service of a line starts only when all of these hold: its queue head has `req_own`=1, `probe_mem` for the line is 1, the directory state is Shared (1), and the line has no eviction in flight. Otherwise no message is sent and the request stays queued.
- R3: A served request produces exactly one invalidate (`msg_type`=0) per holder bit set in the directory, excluding the requester. Invalidates go out in ascending node order and carry the served line in `msg_line`.
- R4: After the last invalidate, one grant (`msg_type`=1) goes to the requester. Its `msg_count` equals the number of invalidates sent for this request (0 if there were none).
- R5: For a requester other than node `HOME`, the cycle after the grant handshake the directory reads Exclusive (2) with only the requester's holder bit set.
- R6: For a requester equal to node `HOME` (node 0 by default), the directory instead reads Stale (3) with only the home node's bit set.
- R7: Requests to one line are served in arrival order, one at a time, and the grant handshake pops the queue head. `req_ready` is 0 while the queue of `req_line` holds `QDEPTH` entries.
- R8: A pulse on `evict_valid` marks the line in flight and holds back its ownership requests. A pulse on `vic_arr_valid` for that line clears the mark, after which service proceeds.
- R9: If `vic_arr_valid` names the line being served while a request is in progress, `victim_clash` is 1 for exactly the following cycle.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_type`, `msg_dest`, `msg_count` and `msg_line` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Queue of `req_line` can accept |
| req_line | input | log2(LINES) | Line addressed by the request |
| req_node | input | log2(NODES) | Requesting node |
| req_own | input | 1 | 1 = request for ownership |
| probe_mem | input | LINES | Per line: memory holds the data |
| evict_valid | input | 1 | Eviction of `evict_line` started |
| evict_line | input | log2(LINES) | Line being evicted |
| vic_arr_valid | input | 1 | Victim of `vic_arr_line` reached memory |
| vic_arr_line | input | log2(LINES) | Line whose victim arrived |
| dir_wr_en | input | 1 | Directory write from other phases |
| dir_wr_line | input | log2(LINES) | Line to write |
| dir_wr_state | input | 2 | State to write |
| dir_wr_owners | input | NODES | Holder vector to write |
| dir_rd_line | input | log2(LINES) | Line to read |
| dir_rd_state | output | 2 | State of `dir_rd_line` |
| dir_rd_owners | output | NODES | Holder vector of `dir_rd_line` |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Network accepts the message |
| msg_type | output | 1 | 0 invalidate, 1 exclusive grant |
| msg_dest | output | log2(NODES) | Destination node |
| msg_count | output | log2(NODES+1) | Invalidate count (grant only) |
| msg_line | output | log2(LINES) | Line the message concerns |
| victim_clash | output | 1 | Victim arrived during service |

## Verification
The assertions check, on every cycle, the properties that can be seen locally. Held messages stay stable under back-pressure. Invalidates climb in node order. The grant count matches the invalidates actually handshaken. Service never starts on a line that is not Shared, whose probe is not from memory, or that has an eviction in flight. After a commit, the directory holds the right state and holder vector, and a clash pulse always follows a victim arrival. The bench scenarios are needed for the rest: the exact set of invalidate destinations against a freshly computed expectation, arrival-order service of queued requests to one line, the queue-full back-pressure, and the waiting behaviour while a request is ineligible.

// File: rtl/rfo_pkg.sv
package rfo_pkg;

  typedef enum logic [1:0] {
    DIR_INVALID = 2'd0,
    DIR_SHARED  = 2'd1,
    DIR_EXCL    = 2'd2,
    DIR_STALE   = 2'd3
  } dir_state_e;

  typedef enum logic {
    MSG_INVAL = 1'b0,
    MSG_GRANT = 1'b1
  } msg_kind_e;

  // Number of set bits in a vector of up to 32 bits.
  function automatic int unsigned count_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += v[i] ? 1 : 0;
    return n;
  endfunction

  // Index of the lowest set bit; 0 when none is set.
  function automatic int unsigned first_set(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) if (v[i]) idx = i;
    return idx;
  endfunction

endpackage

// File: rtl/rfo_line_queue.sv
module rfo_line_queue #(
  parameter int NW     = 2,
  parameter int QDEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [NW-1:0] push_node,
  input  logic          push_own,
  input  logic          pop,
  output logic          empty,
  output logic          full,
  output logic [NW-1:0] head_node,
  output logic          head_own
);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW = $clog2(QDEPTH + 1);

  logic [NW-1:0] node_mem [QDEPTH];
  logic          own_mem  [QDEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(QDEPTH));
  assign head_node = node_mem[rd_ptr];
  assign head_own  = own_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      node_mem[wr_ptr] <= push_node;
      own_mem[wr_ptr]  <= push_own;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rfo_send_engine.sv
module rfo_send_engine import rfo_pkg::*; #(
  parameter int NODES = 4,
  parameter int LINES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [$clog2(LINES)-1:0]     start_line,
  input  logic [$clog2(NODES)-1:0]     start_node,
  input  logic [NODES-1:0]             start_mask,
  input  logic                         msg_ready,
  output logic                         msg_valid,
  output logic                         msg_type,
  output logic [$clog2(NODES)-1:0]     msg_dest,
  output logic [$clog2(NODES+1)-1:0]   msg_count,
  output logic [$clog2(LINES)-1:0]     msg_line,
  output logic                         busy,
  output logic                         done,
  output logic [$clog2(LINES)-1:0]     cur_line,
  output logic [$clog2(NODES)-1:0]     cur_node
);
  localparam int NW = $clog2(NODES);
  localparam int LW = $clog2(LINES);
  localparam int CW = $clog2(NODES + 1);

  logic             busy_q;
  logic [NODES-1:0] mask_q;
  logic [CW-1:0]    cnt_q;
  logic [NW-1:0]    node_q;
  logic [LW-1:0]    line_q;
  logic             pending;
  logic             inv_fire;

  assign pending   = |mask_q;
  assign msg_valid = busy_q;
  assign msg_type  = pending ? MSG_INVAL : MSG_GRANT;
  assign msg_dest  = pending ? NW'(first_set(32'(mask_q))) : node_q;
  assign msg_count = pending ? '0 : cnt_q;
  assign msg_line  = line_q;
  assign inv_fire  = busy_q && pending && msg_ready;
  assign done      = busy_q && !pending && msg_ready;
  assign busy      = busy_q;
  assign cur_line  = line_q;
  assign cur_node  = node_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mask_q <= '0;
      cnt_q  <= '0;
      node_q <= '0;
      line_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      mask_q <= start_mask;
      cnt_q  <= CW'(count_ones(32'(start_mask)));
      node_q <= start_node;
      line_q <= start_line;
    end else if (inv_fire) begin
      mask_q <= mask_q & ~(NODES'(1) << msg_dest);
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rfo_home_ctrl.sv
module rfo_home_ctrl import rfo_pkg::*; #(
  parameter int NODES  = 4,
  parameter int LINES  = 4,
  parameter int QDEPTH = 2,
  parameter int HOME   = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [$clog2(LINES)-1:0]     req_line,
  input  logic [$clog2(NODES)-1:0]     req_node,
  input  logic                         req_own,
  input  logic [LINES-1:0]             probe_mem,
  input  logic                         evict_valid,
  input  logic [$clog2(LINES)-1:0]     evict_line,
  input  logic                         vic_arr_valid,
  input  logic [$clog2(LINES)-1:0]     vic_arr_line,
  input  logic                         dir_wr_en,
  input  logic [$clog2(LINES)-1:0]     dir_wr_line,
  input  logic [1:0]                   dir_wr_state,
  input  logic [NODES-1:0]             dir_wr_owners,
  input  logic [$clog2(LINES)-1:0]     dir_rd_line,
  output logic [1:0]                   dir_rd_state,
  output logic [NODES-1:0]             dir_rd_owners,
  output logic                         msg_valid,
  input  logic                         msg_ready,
  output logic                         msg_type,
  output logic [$clog2(NODES)-1:0]     msg_dest,
  output logic [$clog2(NODES+1)-1:0]   msg_count,
  output logic [$clog2(LINES)-1:0]     msg_line,
  output logic                         victim_clash
);
  localparam int NW = $clog2(NODES);
  localparam int LW = $clog2(LINES);

  // Per-line state
  logic [LINES-1:0][1:0]       dir_state;
  logic [LINES-1:0][NODES-1:0] dir_own;
  logic [LINES-1:0]            inflight;
  logic [LINES-1:0]            q_empty, q_full, q_own, q_push, q_pop, eligible;
  logic [LINES-1:0][NW-1:0]    q_node;

  // Named internal events
  logic                        start;
  logic [LW-1:0]               start_line;
  logic [NW-1:0]               start_node;
  logic [NODES-1:0]            start_mask;
  logic                        eng_busy, eng_done;
  logic [LW-1:0]               cur_line;
  logic [NW-1:0]               cur_node;
  logic                        clash;

  assign req_ready  = !q_full[req_line];
  assign start      = !eng_busy && (|eligible);
  assign start_line = LW'(first_set(32'(eligible)));
  assign start_node = q_node[start_line];
  assign start_mask = dir_own[start_line] & ~(NODES'(1) << start_node);
  assign clash      = vic_arr_valid && eng_busy && (vic_arr_line == cur_line);

  assign dir_rd_state  = dir_state[dir_rd_line];
  assign dir_rd_owners = dir_own[dir_rd_line];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    assign q_push[l]   = req_valid && req_ready && (req_line == LW'(l));
    assign q_pop[l]    = eng_done && (cur_line == LW'(l));
    assign eligible[l] = !q_empty[l] && q_own[l] && probe_mem[l] &&
                         (dir_state[l] == DIR_SHARED) && !inflight[l];

    rfo_line_queue #(.NW(NW), .QDEPTH(QDEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push[l]),
      .push_node (req_node),
      .push_own  (req_own),
      .pop       (q_pop[l]),
      .empty     (q_empty[l]),
      .full      (q_full[l]),
      .head_node (q_node[l]),
      .head_own  (q_own[l])
    );

    // Directory entry: commit of a served request outranks an external write.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir_state[l] <= DIR_INVALID;
        dir_own[l]   <= '0;
      end else if (q_pop[l]) begin
        if (cur_node == NW'(HOME)) begin
          dir_state[l] <= DIR_STALE;
          dir_own[l]   <= NODES'(1) << HOME;
        end else begin
          dir_state[l] <= DIR_EXCL;
          dir_own[l]   <= NODES'(1) << cur_node;
        end
      end else if (dir_wr_en && dir_wr_line == LW'(l)) begin
        dir_state[l] <= dir_wr_state;
        dir_own[l]   <= dir_wr_owners;
      end
    end

    // Eviction in flight: a new eviction start wins over an arrival.
    always_ff @(posedge clk) begin
      if (!rst_n)
        inflight[l] <= 1'b0;
      else if (evict_valid && evict_line == LW'(l))
        inflight[l] <= 1'b1;
      else if (vic_arr_valid && vic_arr_line == LW'(l))
        inflight[l] <= 1'b0;
    end
  end

  rfo_send_engine #(.NODES(NODES), .LINES(LINES)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_line (start_line),
    .start_node (start_node),
    .start_mask (start_mask),
    .msg_ready  (msg_ready),
    .msg_valid  (msg_valid),
    .msg_type   (msg_type),
    .msg_dest   (msg_dest),
    .msg_count  (msg_count),
    .msg_line   (msg_line),
    .busy       (eng_busy),
    .done       (eng_done),
    .cur_line   (cur_line),
    .cur_node   (cur_node)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) victim_clash <= 1'b0;
    else        victim_clash <= clash;
  end
endmodule

// File: rtl/rfo_home_chk.sv
module rfo_home_chk import rfo_pkg::*; #(
  parameter int NODES = 4,
  parameter int LINES = 4,
  parameter int HOME  = 0
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         msg_valid,
  input logic                         msg_ready,
  input logic                         msg_type,
  input logic [$clog2(NODES)-1:0]     msg_dest,
  input logic [$clog2(NODES+1)-1:0]   msg_count,
  input logic [$clog2(LINES)-1:0]     msg_line,
  input logic                         start,
  input logic [$clog2(LINES)-1:0]     start_line,
  input logic [LINES-1:0]             probe_mem,
  input logic [LINES-1:0]             inflight,
  input logic [LINES-1:0][1:0]        dir_state,
  input logic [LINES-1:0][NODES-1:0]  dir_own,
  input logic                         eng_done,
  input logic [$clog2(LINES)-1:0]     cur_line,
  input logic [$clog2(NODES)-1:0]     cur_node,
  input logic                         vic_arr_valid,
  input logic                         victim_clash
);
  localparam int NW = $clog2(NODES);
  localparam int LW = $clog2(LINES);
  localparam int CW = $clog2(NODES + 1);

  logic [CW-1:0] inv_seen;
  logic          done_d;
  logic [LW-1:0] line_d;
  logic [NW-1:0] node_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_seen <= '0;
      done_d   <= 1'b0;
      line_d   <= '0;
      node_d   <= '0;
    end else begin
      if (start) inv_seen <= '0;
      else if (msg_valid && msg_ready && msg_type == MSG_INVAL) inv_seen <= inv_seen + 1'b1;
      done_d <= eng_done;
      line_d <= cur_line;
      node_d <= cur_node;
    end
  end

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_type) && $stable(msg_dest) &&
                                $stable(msg_count) && $stable(msg_line)); // R10

  AST_START_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> dir_state[start_line] == DIR_SHARED && probe_mem[start_line]); // R2

  AST_NO_START_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !inflight[start_line]); // R8

  AST_INVAL_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && msg_type == MSG_INVAL |=>
      (!msg_valid || msg_type == MSG_GRANT || msg_dest > $past(msg_dest))); // R3

  AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == MSG_GRANT |-> msg_count == inv_seen); // R4

  AST_COMMIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done_d && node_d != NW'(HOME) |->
      dir_state[line_d] == DIR_EXCL && dir_own[line_d] == (NODES'(1) << node_d)); // R5

  AST_COMMIT_STALE: assert property (@(posedge clk) disable iff (!rst_n)
    done_d && node_d == NW'(HOME) |->
      dir_state[line_d] == DIR_STALE && dir_own[line_d] == (NODES'(1) << HOME)); // R6

  AST_CLASH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    victim_clash |-> $past(vic_arr_valid)); // R9
endmodule

bind rfo_home_ctrl rfo_home_chk #(.NODES(NODES), .LINES(LINES), .HOME(HOME)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .msg_valid     (msg_valid),
  .msg_ready     (msg_ready),
  .msg_type      (msg_type),
  .msg_dest      (msg_dest),
  .msg_count     (msg_count),
  .msg_line      (msg_line),
  .start         (start),
  .start_line    (start_line),
  .probe_mem     (probe_mem),
  .inflight      (inflight),
  .dir_state     (dir_state),
  .dir_own       (dir_own),
  .eng_done      (eng_done),
  .cur_line      (cur_line),
  .cur_node      (cur_node),
  .vic_arr_valid (vic_arr_valid),
  .victim_clash  (victim_clash)
);

// File: tb/sim_rfo_home_ctrl.sv
module sim_rfo_home_ctrl;
  localparam int NODES = 4;
  localparam int LINES = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_ready, req_own = 1'b1;
  logic [1:0] req_line = '0, req_node = '0;
  logic [3:0] probe_mem = 4'hF;
  logic       evict_valid = 1'b0, vic_arr_valid = 1'b0;
  logic [1:0] evict_line = '0, vic_arr_line = '0;
  logic       dir_wr_en = 1'b0;
  logic [1:0] dir_wr_line = '0, dir_wr_state = '0, dir_rd_line = '0, dir_rd_state;
  logic [3:0] dir_wr_owners = '0, dir_rd_owners;
  logic       msg_valid, msg_ready = 1'b0, msg_type, victim_clash;
  logic [1:0] msg_dest, msg_line;
  logic [2:0] msg_count;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rfo_home_ctrl #(.NODES(NODES), .LINES(LINES), .QDEPTH(2), .HOME(0)) u0 (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ones(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic dir_write(input int line, input int st, input logic [3:0] own);
    @(negedge clk);
    dir_wr_en = 1'b1; dir_wr_line = 2'(line); dir_wr_state = 2'(st); dir_wr_owners = own;
    @(negedge clk);
    dir_wr_en = 1'b0;
  endtask

  task automatic push(input int line, input int node, input bit own);
    @(negedge clk);
    req_line = 2'(line); req_node = 2'(node); req_own = own;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Collect invalidates and the grant of one served request (R3, R4, R10).
  task automatic collect(input int line, input int node, input logic [3:0] mask);
    int idx = 0, sent = 0, t = 0;
    bit got = 1'b0, held = 1'b0;
    logic [7:0] prev = '0;
    while (!got && t < 400) begin
      @(negedge clk);
      #1;
      if (held) check({msg_valid, msg_type, msg_dest, msg_count, msg_line} == {1'b1, prev[7:0]},
                      "R10", "held message changed", int'(msg_dest), int'(prev[5:4]));
      msg_ready = ($urandom % 100) < 70;
      #1;
      held = msg_valid && !msg_ready;
      prev = {msg_type, msg_dest, msg_count, msg_line};
      if (msg_valid && msg_ready) begin
        check(msg_line == 2'(line), "R3", "message line", int'(msg_line), line);
        if (msg_type == 1'b0) begin
          while (idx < NODES && !mask[idx]) idx++;
          check(int'(msg_dest) == idx, "R3", "invalidate destination", int'(msg_dest), idx);
          idx++;
          sent++;
        end else begin
          check(sent == ones(mask), "R3", "invalidates before grant", sent, ones(mask));
          check(int'(msg_count) == ones(mask), "R4", "grant count", int'(msg_count), ones(mask));
          check(int'(msg_dest) == node, "R4", "grant destination", int'(msg_dest), node);
          got = 1'b1;
        end
      end
      t++;
    end
    @(negedge clk);
    msg_ready = 1'b0;
    if (!got) check(1'b0, "R4", "grant never seen", 0, 1);
  endtask

  task automatic check_dir(input int line, input int st, input logic [3:0] own, input string req);
    @(negedge clk);
    dir_rd_line = 2'(line);
    #1;
    check(int'(dir_rd_state) == st, req, "directory state", int'(dir_rd_state), st);
    check(dir_rd_owners == own, req, "directory holders", int'(dir_rd_owners), int'(own));
  endtask

  task automatic expect_commit(input int line, input int node);
    if (node == 0) check_dir(line, 3, 4'b0001, "R6");
    else           check_dir(line, 2, 4'(1 << node), "R5");
  endtask

  task automatic run(input int line, input int node, input logic [3:0] own);
    dir_write(line, 1, own);
    push(line, node, 1'b1);
    collect(line, node, own & ~4'(1 << node));
    expect_commit(line, node);
  endtask

  task automatic expect_quiet(input int cycles, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      #1;
      if (msg_valid) seen = 1'b1;
    end
    check(!seen, req, "message while ineligible", int'(seen), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(!msg_valid, "R1", "msg_valid after reset", int'(msg_valid), 0);
    check(!victim_clash, "R1", "victim_clash after reset", int'(victim_clash), 0);
    check(req_ready, "R1", "req_ready after reset", int'(req_ready), 1);
    for (int l = 0; l < LINES; l++) check_dir(l, 0, 4'b0000, "R1");

    // Directed: remote requester among all holders, home requester, lone holder
    run(1, 2, 4'b1111);
    run(2, 0, 4'b1110);
    run(0, 1, 4'b0010);
    run(0, 3, 4'b0000);

    // Random mix
    for (int i = 0; i < 40; i++)
      run(int'($urandom % 3), int'($urandom % 4), 4'($urandom));

    // R2: directory not Shared holds the request
    dir_write(0, 2, 4'b0100);
    push(0, 1, 1'b1);
    expect_quiet(12, "R2");
    dir_write(0, 1, 4'b1001);
    collect(0, 1, 4'b1001);
    expect_commit(0, 1);

    // R2: probe says memory does not hold the data
    probe_mem[0] = 1'b0;
    dir_write(0, 1, 4'b0110);
    push(0, 3, 1'b1);
    expect_quiet(12, "R2");
    probe_mem[0] = 1'b1;
    collect(0, 3, 4'b0110);
    expect_commit(0, 3);

    // R8: eviction in flight blocks until its victim arrives
    @(negedge clk); evict_valid = 1'b1; evict_line = 2'd1;
    @(negedge clk); evict_valid = 1'b0;
    dir_write(1, 1, 4'b0011);
    push(1, 2, 1'b1);
    expect_quiet(12, "R8");
    @(negedge clk); vic_arr_valid = 1'b1; vic_arr_line = 2'd1;
    @(negedge clk); vic_arr_valid = 1'b0;
    collect(1, 2, 4'b0011);
    expect_commit(1, 2);

    // R9: victim arrival for the line being served
    msg_ready = 1'b0;
    dir_write(2, 1, 4'b1111);
    push(2, 1, 1'b1);
    repeat (3) @(negedge clk);
    #1;
    check(msg_valid && msg_type == 1'b0 && msg_dest == 2'd0, "R10",
          "message held without ready", int'(msg_dest), 0);
    @(negedge clk); vic_arr_valid = 1'b1; vic_arr_line = 2'd2;
    @(negedge clk); vic_arr_valid = 1'b0;
    #1;
    check(victim_clash, "R9", "clash flag after arrival", int'(victim_clash), 1);
    @(negedge clk); #1;
    check(!victim_clash, "R9", "clash flag one cycle only", int'(victim_clash), 0);
    collect(2, 1, 4'b1101);
    expect_commit(2, 1);

    // R7: two queued requests to one line, served in order; full queue refuses
    msg_ready = 1'b0;
    dir_write(1, 1, 4'b0111);
    push(1, 2, 1'b1);
    push(1, 3, 1'b1);
    @(negedge clk);
    req_line = 2'd1;
    #1;
    check(!req_ready, "R7", "req_ready with full queue", int'(req_ready), 0);
    collect(1, 2, 4'b0011);
    expect_commit(1, 2);
    dir_write(1, 1, 4'b0111);
    collect(1, 3, 4'b0111);
    expect_commit(1, 3);
    @(negedge clk); req_line = 2'd1; #1;
    check(req_ready, "R7", "req_ready after queue drained", int'(req_ready), 1);

    // R2: a request that is not for ownership is never served here
    dir_write(3, 1, 4'b1111);
    push(3, 1, 1'b0);
    expect_quiet(12, "R2");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule